// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block runs one stack-machine command at a time. Operands never name a register: they sit in a small operand stack that is held in an internal memory and managed by a stack pointer. The block can push a literal, push a word fetched from a small internal data RAM, pop the top entry into that RAM, or combine the two topmost entries with add, subtract, multiply or divide. The result replaces both entries.

A sequencer outside the block presents an opcode and an argument with a valid strobe. It then waits for the one-cycle done pulse before it sends the next command. The argument is either the literal value or, in its low bits, a data RAM word address. The current top of stack and the error code of the last completed command are always visible at the ports. The stack grows toward lower indices: a push first decrements the pointer and then writes, and a pop reads and then increments the pointer.

Top module: `stk_exec_unit`

## Requirements
- R1: After reset the stack is empty, tos reads 0, busy and done are low, err_code is 0 (none), and every data RAM word reads 0.
- R2: A command is accepted on a clock edge where cmd_valid is high and busy is low. busy is high for exactly the next cycle, and done is high for exactly one cycle, two cycles after acceptance. cmd_valid while busy is high is ignored.
- R3: Opcode 1 (push literal) places cmd_arg on top of the stack, so tos equals cmd_arg.
- R4: Opcode 2 (pop) writes the top entry to the data RAM word addressed by the low address bits of cmd_arg and removes it. Opcode 0 (push from RAM) places that RAM word on top.
- R5: Opcodes 3 (add) and 4 (subtract) compute TOS+NOS and TOS−NOS modulo 2^W. The two entries are replaced by the single result.
- R6: Opcode 5 (multiply) leaves the low W bits of TOS×NOS. Opcode 6 (divide) leaves the unsigned quotient TOS/NOS. Both consume two entries and push one.
- R7: A divide with NOS equal to zero pushes the all-ones value and sets err_code to 3 (divide by zero). The two operands are still consumed.
- R8: A binary opcode with fewer than two entries, or a pop on an empty stack, sets err_code to 1 (underflow) and changes neither the stack nor the RAM.
- R9: A push when all DEPTH entries are in use sets err_code to 2 (overflow) and leaves the stack unchanged.
- R10: The stack holds exactly DEPTH entries and returns them in last-in, first-out order.
- R11: Opcode 7 is a no-operation: it completes with done and err_code 0 and changes nothing.
- R12: err_code is updated only when a command completes and holds its value until the next completion. A command that completes without error writes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode (0 push RAM, 1 push literal, 2 pop, 3 add, 4 sub, 5 mul, 6 div, 7 nop) |
| cmd_arg | input | W | Literal value, or data RAM address in its low bits |
| busy | output | 1 | Command held and executing; new strobes are ignored |
| done | output | 1 | One-cycle completion pulse |
| tos | output | W | Current top-of-stack value, 0 when empty |
| err_code | output | 2 | Result of last command: 0 none, 1 underflow, 2 overflow, 3 divide by zero |

## Verification
A stack pointer that is off by one shows up on tos in the same cycle as the done pulse of the next push or operation. It also shows up as a false underflow or overflow code on the command that reaches the true depth boundary. A corrupted stack entry or RAM word stays hidden until the entry is popped or combined, so the sequences fill the stack to its limit and then drain it completely. They also move data through the RAM and back. Latency faults show up one cycle off on busy and done, which the reference model compares on every cycle.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH_MEM = 3'd0,
    OP_PUSH_IMM = 3'd1,
    OP_POP_MEM  = 3'd2,
    OP_ADD      = 3'd3,
    OP_SUB      = 3'd4,
    OP_MUL      = 3'd5,
    OP_DIV      = 3'd6,
    OP_NOP      = 3'd7
  } stk_op_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_UNDER = 2'd1,
    ERR_OVER  = 2'd2,
    ERR_DIVZ  = 2'd3
  } stk_err_e;
endpackage

// File: rtl/stk_regmem.sv
// Operand stack storage: one write port, two combinational read ports.
module stk_regmem #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr_a,
  output logic [W-1:0]             rdata_a,
  input  logic [$clog2(DEPTH)-1:0] raddr_b,
  output logic [W-1:0]             rdata_b
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/stk_ptr.sv
// Stack pointer: DEPTH means empty, 0 means full.
module stk_ptr #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dec,
  input  logic                       inc,
  output logic [$clog2(DEPTH+1)-1:0] sp
);
  localparam int SPW = $clog2(DEPTH+1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp <= SPW'(DEPTH);
    else if (dec) sp <= sp - SPW'(1);
    else if (inc) sp <= sp + SPW'(1);
  end
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = 16
) (
  input  stk_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         div_zero
);
  function automatic logic [W-1:0] f_add(logic [W-1:0] x, logic [W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [W-1:0] f_sub(logic [W-1:0] x, logic [W-1:0] y);
    return x - y;
  endfunction

  function automatic logic [W-1:0] f_mul(logic [W-1:0] x, logic [W-1:0] y);
    logic [2*W-1:0] p;
    p = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    return p[W-1:0];
  endfunction

  function automatic logic [W-1:0] f_div(logic [W-1:0] x, logic [W-1:0] y);
    if (y == '0) return '1;
    return x / y;
  endfunction

  always_comb begin
    div_zero = 1'b0;
    case (op)
      OP_ADD:  res = f_add(a, b);
      OP_SUB:  res = f_sub(a, b);
      OP_MUL:  res = f_mul(a, b);
      OP_DIV: begin
        res      = f_div(a, b);
        div_zero = (b == '0);
      end
      default: res = a;
    endcase
  end
endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit
  import stk_pkg::*;
#(
  parameter int W         = 16,
  parameter int DEPTH     = 16,
  parameter int MEM_WORDS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_arg,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] tos,
  output logic [1:0]   err_code
);
  localparam int SAW = $clog2(DEPTH);
  localparam int SPW = $clog2(DEPTH+1);
  localparam int MAW = $clog2(MEM_WORDS);

  // command holding stage
  logic         pend_q, done_q;
  stk_op_e      op_q;
  logic [W-1:0] arg_q;
  stk_err_e     err_q;

  // named internal events for the checker
  logic           exec_fire, ovf_evt, unf_evt, dz_evt;
  logic [SPW-1:0] sp_cur;

  logic is_push, is_pop, is_bin;
  logic st_full, st_empty, st_two;
  logic push_ok, pop_ok, bin_ok;
  logic [SAW-1:0] tos_idx, nos_idx, push_idx;
  logic [W-1:0]   tos_val, nos_val, alu_res, push_val;
  logic           alu_dz;
  logic           stk_we;
  logic [SAW-1:0] stk_waddr;
  logic [W-1:0]   stk_wdata;

  logic [W-1:0]   dmem [MEM_WORDS];
  logic [MAW-1:0] dm_addr;

  wire accept = cmd_valid & ~pend_q;
  assign exec_fire = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      op_q   <= OP_NOP;
      arg_q  <= '0;
    end else if (accept) begin
      pend_q <= 1'b1;
      op_q   <= stk_op_e'(cmd_op);
      arg_q  <= cmd_arg;
    end else if (exec_fire) begin
      pend_q <= 1'b0;
    end
  end

  // decode and stack boundary checks
  assign is_push  = (op_q == OP_PUSH_MEM) || (op_q == OP_PUSH_IMM);
  assign is_pop   = (op_q == OP_POP_MEM);
  assign is_bin   = (op_q == OP_ADD) || (op_q == OP_SUB) ||
                    (op_q == OP_MUL) || (op_q == OP_DIV);
  assign st_full  = (sp_cur == '0);
  assign st_empty = (sp_cur == SPW'(DEPTH));
  assign st_two   = (sp_cur <= SPW'(DEPTH - 2));

  assign push_ok = exec_fire & is_push & ~st_full;
  assign pop_ok  = exec_fire & is_pop  & ~st_empty;
  assign bin_ok  = exec_fire & is_bin  & st_two;
  assign ovf_evt = exec_fire & is_push & st_full;
  assign unf_evt = exec_fire & ((is_pop & st_empty) | (is_bin & ~st_two));
  assign dz_evt  = bin_ok & alu_dz;

  stk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk (clk),
    .rst_n (rst_n),
    .dec (push_ok),
    .inc (pop_ok | bin_ok),
    .sp  (sp_cur)
  );

  assign tos_idx  = sp_cur[SAW-1:0];
  assign nos_idx  = sp_cur[SAW-1:0] + SAW'(1);
  assign push_idx = sp_cur[SAW-1:0] - SAW'(1);

  stk_alu #(.W(W)) u_alu (
    .op       (op_q),
    .a        (tos_val),
    .b        (nos_val),
    .res      (alu_res),
    .div_zero (alu_dz)
  );

  // data RAM
  assign dm_addr  = arg_q[MAW-1:0];
  assign push_val = (op_q == OP_PUSH_MEM) ? dmem[dm_addr] : arg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) dmem[i] <= '0;
    end else if (pop_ok) begin
      dmem[dm_addr] <= tos_val;
    end
  end

  // stack write: push at the pre-decremented slot, result at the old NOS slot
  assign stk_we    = push_ok | bin_ok;
  assign stk_waddr = push_ok ? push_idx : nos_idx;
  assign stk_wdata = push_ok ? push_val : alu_res;

  stk_regmem #(.W(W), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (stk_we),
    .waddr   (stk_waddr),
    .wdata   (stk_wdata),
    .raddr_a (tos_idx),
    .rdata_a (tos_val),
    .raddr_b (nos_idx),
    .rdata_b (nos_val)
  );

  // completion and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      done_q <= exec_fire;
      if (exec_fire) begin
        if (ovf_evt)      err_q <= ERR_OVER;
        else if (unf_evt) err_q <= ERR_UNDER;
        else if (dz_evt)  err_q <= ERR_DIVZ;
        else              err_q <= ERR_NONE;
      end
    end
  end

  assign busy     = pend_q;
  assign done     = done_q;
  assign tos      = st_empty ? '0 : tos_val;
  assign err_code = err_q;
endmodule

// File: rtl/stk_exec_unit_chk.sv
module stk_exec_unit_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic                       busy,
  input logic                       done,
  input logic [W-1:0]               tos,
  input logic [1:0]                 err_code,
  input logic                       exec_fire,
  input logic                       ovf_evt,
  input logic                       unf_evt,
  input logic                       dz_evt,
  input logic [$clog2(DEPTH+1)-1:0] sp_cur
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy ##1 (done && !busy)); // R2

  AST_EXEC_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire |=> done); // R2

  AST_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> (sp_cur == $past(sp_cur)) && (err_code == 2'd1)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (sp_cur == $past(sp_cur)) && (err_code == 2'd2)); // R9

  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp_cur <= ($clog2(DEPTH+1))'(DEPTH)); // R10

  AST_DIVZ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    dz_evt |=> (err_code == 2'd3) && (tos == '1)); // R7

  AST_ERR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(err_code)); // R12
endmodule

bind stk_exec_unit stk_exec_unit_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .tos       (tos),
  .err_code  (err_code),
  .exec_fire (exec_fire),
  .ovf_evt   (ovf_evt),
  .unf_evt   (unf_evt),
  .dz_evt    (dz_evt),
  .sp_cur    (sp_cur)
);

// File: tb/test_stk_exec_unit.sv
module test_stk_exec_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int DEPTH = 16;
  localparam int MEM_WORDS = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_op = 3'd7;
  logic [W-1:0] cmd_arg = '0;
  logic         busy, done;
  logic [W-1:0] tos;
  logic [1:0]   err_code;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  stk_exec_unit #(.W(W), .DEPTH(DEPTH), .MEM_WORDS(MEM_WORDS)) i_stk_exec_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .busy(busy), .done(done), .tos(tos), .err_code(err_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model: queue front is the top of stack
  logic [W-1:0] m_stk [$];
  logic [W-1:0] m_mem [MEM_WORDS];
  bit           m_busy, m_done;
  logic [1:0]   m_err;
  int           p_op;
  logic [W-1:0] p_arg;

  task automatic model_exec();
    logic [W-1:0] a, b, r;
    int adr;
    adr = int'(p_arg) % MEM_WORDS;
    m_err = 2'd0;
    case (p_op)
      0, 1: begin
        if (m_stk.size() == DEPTH) m_err = 2'd2;
        else m_stk.push_front(p_op == 0 ? m_mem[adr] : p_arg);
      end
      2: begin
        if (m_stk.size() == 0) m_err = 2'd1;
        else m_mem[adr] = m_stk.pop_front();
      end
      3, 4, 5, 6: begin
        if (m_stk.size() < 2) m_err = 2'd1;
        else begin
          a = m_stk.pop_front();
          b = m_stk.pop_front();
          case (p_op)
            3: r = W'(int'(a) + int'(b));
            4: r = W'(int'(a) - int'(b));
            5: r = W'(longint'(a) * longint'(b));
            default: begin
              if (b == 0) begin r = {W{1'b1}}; m_err = 2'd3; end
              else r = W'(int'(a) / int'(b));
            end
          endcase
          m_stk.push_front(r);
        end
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stk.delete();
      for (int i = 0; i < MEM_WORDS; i++) m_mem[i] = '0;
      m_busy = 0; m_done = 0; m_err = 2'd0;
    end else if (m_busy) begin
      model_exec();
      m_busy = 0; m_done = 1;
    end else begin
      m_done = 0;
      if (cmd_valid) begin
        m_busy = 1; p_op = int'(cmd_op); p_arg = cmd_arg;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    logic [W-1:0] etos;
    if (rst_n) begin
      etos = (m_stk.size() == 0) ? '0 : m_stk[0];
      n_cmp++;
      if (busy !== m_busy || done !== m_done || tos !== etos || err_code !== m_err) begin
        n_bad++;
        $display("FAIL %s busy/done/tos/err actual=%0b/%0b/%h/%0d expected=%0b/%0b/%h/%0d",
                 cur_req, busy, done, tos, err_code, m_busy, m_done, etos, m_err);
      end
    end
  end

  task automatic expect_now(string req, logic [W-1:0] etos, logic [1:0] eerr);
    n_cmp++;
    if (done !== 1'b1 || tos !== etos || err_code !== eerr) begin
      n_bad++;
      $display("FAIL %s done/tos/err actual=%0b/%h/%0d expected=1/%h/%0d",
               req, done, tos, err_code, etos, eerr);
    end
  endtask

  // issue one command, return at the negedge where done is high
  task automatic cmd(int op, logic [W-1:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    n_cmp++;
    if (tos !== '0 || busy !== 1'b0 || done !== 1'b0 || err_code !== 2'd0) begin
      n_bad++;
      $display("FAIL R1 reset tos/busy/done/err actual=%h/%0b/%0b/%0d expected=0/0/0/0",
               tos, busy, done, err_code);
    end

    cur_req = "R8";
    cmd(3, '0);             expect_now("R8", 16'h0000, 2'd1);
    cmd(2, 16'd4);          expect_now("R8", 16'h0000, 2'd1);

    cur_req = "R1";
    cmd(0, 16'd4);          expect_now("R1", 16'h0000, 2'd0);
    cmd(2, 16'd4);

    cur_req = "R3";
    cmd(1, 16'h1234);       expect_now("R3", 16'h1234, 2'd0);
    cur_req = "R12";
    cmd(7, '0);             expect_now("R12", 16'h1234, 2'd0);

    cur_req = "R4";
    cmd(2, 16'h0025);       expect_now("R4", 16'h0000, 2'd0);
    cmd(0, 16'h0005);       expect_now("R4", 16'h1234, 2'd0);
    cmd(0, 16'h0009);       expect_now("R4", 16'h0000, 2'd0);

    cur_req = "R8";
    cmd(2, 16'd3);          // drop the zero
    cmd(4, '0);             expect_now("R8", 16'h1234, 2'd1);
    cmd(2, 16'd3);          expect_now("R8", 16'h0000, 2'd0);

    cur_req = "R5";
    cmd(1, 16'd5); cmd(1, 16'd3); cmd(4, '0); expect_now("R5", 16'hFFFE, 2'd0);
    cmd(1, 16'h0003); cmd(3, '0);              expect_now("R5", 16'h0001, 2'd0);
    cmd(2, 16'd1);                             expect_now("R5", 16'h0000, 2'd0);

    cur_req = "R6";
    cmd(1, 16'h0300); cmd(1, 16'h0101); cmd(5, '0); expect_now("R6", 16'h0300, 2'd0);
    cmd(2, 16'd1);
    cmd(1, 16'd3); cmd(1, 16'd17); cmd(6, '0);      expect_now("R6", 16'h0005, 2'd0);
    cmd(2, 16'd1);

    cur_req = "R7";
    cmd(1, 16'd0); cmd(1, 16'd7); cmd(6, '0);       expect_now("R7", 16'hFFFF, 2'd3);
    cmd(2, 16'd1);                                   expect_now("R7", 16'h0000, 2'd0);

    cur_req = "R11";
    cmd(1, 16'h00AA); cmd(7, 16'h5555);             expect_now("R11", 16'h00AA, 2'd0);
    cmd(2, 16'd2);

    cur_req = "R2";
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_arg = 16'h0077;
    @(negedge clk);
    cmd_op = 3'd1; cmd_arg = 16'h0099;    // held while busy: ignored
    @(negedge clk);
    cmd_valid = 1'b0;
    expect_now("R2", 16'h0077, 2'd0);
    repeat (2) @(negedge clk);
    cmd(2, 16'd2);                         expect_now("R2", 16'h0000, 2'd0);

    cur_req = "R10";
    for (int i = 0; i < DEPTH; i++) cmd(1, W'(16'h0100 + i));
    expect_now("R10", 16'h010F, 2'd0);
    cur_req = "R9";
    cmd(1, 16'hDEAD);                      expect_now("R9", 16'h010F, 2'd2);
    cmd(0, 16'd0);                         expect_now("R9", 16'h010F, 2'd2);
    cur_req = "R10";
    for (int i = DEPTH - 1; i >= 1; i--) begin
      cmd(2, 16'd6);
      expect_now("R10", W'(16'h0100 + i - 1), 2'd0);
    end
    cmd(2, 16'd6);                         expect_now("R10", 16'h0000, 2'd0);
    cmd(0, 16'd6);                         expect_now("R10", 16'h0100, 2'd0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule